// File: doc/BRIEF.md
# Oversampling UART start-bit detector

This block is the front end of a UART receiver. It watches the receive line at sixteen samples per bit period, paced by a one-cycle sample tick, and decides whether a high-to-low transition is a real start bit or a short glitch. The raw line first passes through a two-flop synchroniser, and the detector sees only the synchronised value.

While the line is idle, the first tick that reads a low level is numbered sample 1 and starts a phase count. The levels seen at samples 8, 9 and 10 are then put to a two-of-three vote. A low majority accepts the start bit and issues a one-cycle `start_ok` pulse. A high majority rejects the edge and issues a one-cycle `start_noise` pulse. After acceptance the phase counter keeps running, so downstream bit-sampling logic can vote every later bit at the same tick positions.

The detector ignores the line until the frame has run its course: 9 or 10 further bit periods, chosen by `frame_long`. It then needs a high sample before it can arm again. The same rule applies after a rejected edge.

Top module: `uart_start_detect`

## Requirements
- R1: The line passes through two flops before detection. A level that reaches `rxd_in` only one clock before a tick edge is not seen by that tick. A level present two clocks before the tick edge is seen.
- R2: During and after reset, `start_ok` and `start_noise` are 0 and `phase` is 0. After reset, a line that is already low is not taken as an edge until a tick has read it high.
- R3: While hunting, the first tick that reads low is sample 1. `phase` reads 0 after it, and `phase` changes only on ticks, advancing by one per tick.
- R4: If at least two of samples 8, 9 and 10 read low, `start_ok` is high for exactly one clock, in the cycle after the tick of sample 10. `phase` reads 9 in that cycle.
- R5: If at least two of samples 8, 9 and 10 read high, `start_noise` is high for one clock with the same timing. `phase` returns to 0, and a new edge is accepted only after a later tick has read the line high.
- R6: Samples 2 to 7, and samples after 10, have no effect on the verdict.
- R7: During an accepted frame, low samples start no new detection and raise no pulse. `phase` counts the tick index since sample 1, modulo 16.
- R8: With `frame_long` = 0 the frame ends on the tick 160 ticks after sample 1 (9 further bit periods). With `frame_long` = 1 it ends 176 ticks after sample 1 (10 further bit periods). If the end tick reads high, the next low tick is a new sample 1. If it reads low, the detector waits for a high tick.
- R9: `start_ok` and `start_noise` are never high together, and each rises only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_16x | input | 1 | One-cycle strobe at 16 times the baud rate |
| rxd_in | input | 1 | Asynchronous receive line, idle high |
| frame_long | input | 1 | 0: 9 bit periods follow the start bit; 1: 10 follow |
| start_ok | output | 1 | One-cycle pulse: start bit accepted |
| start_noise | output | 1 | One-cycle pulse: edge rejected as a spike |
| phase | output | 4 | Tick position inside the current bit period (0 to 15) |

## Verification
A wrong phase or vote state shows at the ports within ten ticks of an edge. Either the verdict pulse is missing or of the wrong kind, or `phase` does not read 9 when `start_ok` fires. A wrong frame counter shows up at the end of the frame, within one tick of the boundary. In that case `phase` either keeps counting where it should have dropped to 0, or stays at 0 while a low line is being ignored. A stuck re-arm state shows at the next high-then-low transition, through a missing or unexpected pulse ten ticks later.

// File: rtl/uart_sd_pkg.sv
package uart_sd_pkg;

  typedef enum logic [1:0] {
    SD_ARM   = 2'd0,   // waiting for a high sample
    SD_HUNT  = 2'd1,   // waiting for a low sample
    SD_START = 2'd2,   // counting towards the vote
    SD_FRAME = 2'd3    // frame in progress, line ignored
  } sd_state_e;

  // two-of-three majority, returns 1 when most inputs are high
  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // sample number taken by a tick whose current phase is p is p + 2
  function automatic logic vote_slot(input int unsigned p, input int unsigned first);
    return ((p + 2) >= first) && ((p + 2) <= (first + 2));
  endfunction

  // bit periods that follow the start bit
  function automatic int unsigned tail_bits(input logic long_sel,
                                            input int unsigned short_n,
                                            input int unsigned long_n);
    return long_sel ? long_n : short_n;
  endfunction

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= IDLE;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= IDLE;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/sd_vote.sv
module sd_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic rxd,
  output logic accept
);
  import uart_sd_pkg::*;

  // hist[1] holds the older vote sample, hist[0] the newer
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist <= 2'b11;
    else if (cap) hist <= {hist[0], rxd};
  end

  // the third vote is the level on the deciding tick itself
  assign accept = ~majority3(hist[1], hist[0], rxd);

endmodule

// File: rtl/sd_ctrl.sv
module sd_ctrl #(
  parameter int OVS        = 16,
  parameter int VOTE_FIRST = 8,
  parameter int SHORT_BITS = 9,
  parameter int LONG_BITS  = 10,
  localparam int PW = $clog2(OVS),
  localparam int BW = $clog2(LONG_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          frame_long,
  input  logic          accept,
  output logic          decide,
  output logic          vote_cap,
  output logic          start_ok,
  output logic          start_noise,
  output logic [PW-1:0] phase
);
  import uart_sd_pkg::*;

  localparam logic [PW-1:0] PH_LAST   = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_DECIDE = PW'(VOTE_FIRST);

  sd_state_e       state;
  logic [BW-1:0]   nbits;
  logic [BW-1:0]   target;
  logic            frame_last;

  assign target     = BW'(tail_bits(frame_long, SHORT_BITS, LONG_BITS));
  assign frame_last = (nbits == target);
  assign vote_cap   = tick && (state == SD_START) && vote_slot(int'(phase), VOTE_FIRST);
  assign decide     = tick && (state == SD_START) && (phase == PH_DECIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SD_ARM;
      phase       <= '0;
      nbits       <= '0;
      start_ok    <= 1'b0;
      start_noise <= 1'b0;
    end else begin
      start_ok    <= 1'b0;
      start_noise <= 1'b0;
      if (tick) begin
        unique case (state)
          SD_ARM: begin
            if (rxd) state <= SD_HUNT;
          end
          SD_HUNT: begin
            if (!rxd) begin
              state <= SD_START;
              phase <= '0;
              nbits <= '0;
            end
          end
          SD_START: begin
            phase <= phase + 1'b1;
            if (decide) begin
              if (accept) begin
                start_ok <= 1'b1;
                state    <= SD_FRAME;
              end else begin
                start_noise <= 1'b1;
                state       <= SD_ARM;
                phase       <= '0;
              end
            end
          end
          SD_FRAME: begin
            phase <= phase + 1'b1;
            if (phase == PH_LAST) begin
              if (frame_last) state <= rxd ? SD_HUNT : SD_ARM;
              else            nbits <= nbits + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_start_detect.sv
module uart_start_detect #(
  parameter int OVS         = 16,
  parameter int VOTE_FIRST  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_BITS  = 9,
  parameter int LONG_BITS   = 10,
  localparam int PW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_16x,
  input  logic          rxd_in,
  input  logic          frame_long,
  output logic          start_ok,
  output logic          start_noise,
  output logic [PW-1:0] phase
);

  // internal events, named so the checker can reach them
  logic rxd_s;
  logic vote_cap;
  logic decide;
  logic accept;

  sd_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd_in),
    .q     (rxd_s)
  );

  sd_vote u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (vote_cap),
    .rxd    (rxd_s),
    .accept (accept)
  );

  sd_ctrl #(
    .OVS        (OVS),
    .VOTE_FIRST (VOTE_FIRST),
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_16x),
    .rxd         (rxd_s),
    .frame_long  (frame_long),
    .accept      (accept),
    .decide      (decide),
    .vote_cap    (vote_cap),
    .start_ok    (start_ok),
    .start_noise (start_noise),
    .phase       (phase)
  );

endmodule

// File: rtl/sd_chk.sv
module sd_chk #(
  parameter int PW     = 4,
  parameter int DEC_PH = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          decide,
  input logic          accept,
  input logic          start_ok,
  input logic          start_noise,
  input logic [PW-1:0] phase
);

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && start_noise));

  // R9
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_ok) || $rose(start_noise) |-> $past(tick));

  // R4
  ok_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !start_ok);

  // R5
  noise_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_noise |=> !start_noise);

  // R4
  ok_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (phase == PW'(DEC_PH)));

  // R4
  verdict_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide && accept |=> start_ok);

  // R5
  verdict_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !accept |=> start_noise && (phase == '0));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

endmodule

bind uart_start_detect sd_chk #(.PW(PW), .DEC_PH(VOTE_FIRST + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick_16x),
  .decide      (decide),
  .accept      (accept),
  .start_ok    (start_ok),
  .start_noise (start_noise),
  .phase       (phase)
);

// File: tb/uart_start_detect_tb.sv
module uart_start_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_16x;
  logic       rxd_in;
  logic       frame_long;
  logic       start_ok;
  logic       start_noise;
  logic [3:0] phase;
  int         total = 0;
  int         bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_start_detect u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_16x    (tick_16x),
    .rxd_in      (rxd_in),
    .frame_long  (frame_long),
    .start_ok    (start_ok),
    .start_noise (start_noise),
    .phase       (phase)
  );

  // {verdict (1 accept, 2 reject), samples {10,9,8}, other samples s at bit s-1}
  localparam logic [20:0] VEC [9] = '{
    {2'd1, 3'b000, 16'h0000},
    {2'd2, 3'b111, 16'h0000},
    {2'd1, 3'b001, 16'h0000},
    {2'd2, 3'b011, 16'h0000},
    {2'd1, 3'b100, 16'h0000},
    {2'd2, 3'b101, 16'h0000},
    {2'd1, 3'b010, 16'h0000},
    {2'd2, 3'b110, 16'h0000},
    {2'd1, 3'b000, 16'hFC7E}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one sample tick: the level is set three clocks before the tick edge
  task automatic do_tick(input logic v);
    @(negedge clk);
    // R4 R9: pulses last one clock and follow only tick cycles
    chk(!start_ok && !start_noise, "R4 R9", "pulse outside tick slot",
        int'({start_ok, start_noise}), 0);
    rxd_in = v;
    tick_16x = 1'b0;
    repeat (2) @(negedge clk);
    tick_16x = 1'b1;
    @(negedge clk);
    tick_16x = 1'b0;
  endtask

  task automatic tick_chk(input logic v, input logic eo, input logic en,
                          input int ep, input string req);
    do_tick(v);
    chk(start_ok == eo, req, "start_ok", int'(start_ok), int'(eo));
    chk(start_noise == en, req, "start_noise", int'(start_noise), int'(en));
    chk(int'(phase) == ep, req, "phase", int'(phase), ep);
  endtask

  task automatic run_vec(input logic [20:0] vec, input logic long_sel);
    logic [1:0]  verdict;
    logic [15:0] pat;
    int          last;
    verdict = vec[20:19];
    pat = vec[15:0];
    pat[9:7] = vec[18:16];
    frame_long = long_sel;
    for (int k = 0; k < 3; k++) tick_chk(1'b1, 1'b0, 1'b0, 0, "R3 idle");
    for (int s = 1; s <= 16; s++) begin
      tick_chk(pat[s-1], (s == 10) && (verdict == 2'd1), (s == 10) && (verdict == 2'd2),
               ((verdict == 2'd2) && (s >= 10)) ? 0 : s - 1,
               (verdict == 2'd1) ? "R4 R6" : "R5 R6");
    end
    if (verdict == 2'd1) begin
      last = long_sel ? 176 : 160;
      for (int i = 16; i <= last; i++)
        tick_chk(i >= last - 15, 1'b0, 1'b0, i % 16, "R7 R8");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tick_16x = 1'b0;
    rxd_in = 1'b0;
    frame_long = 1'b0;
    repeat (3) @(negedge clk);
    chk(!start_ok && !start_noise && phase == 4'd0, "R2", "reset outputs",
        int'({start_ok, start_noise, phase}), 0);
    rst_n = 1'b1;

    // R2: a line low from reset is ignored until seen high
    for (int k = 0; k < 20; k++) tick_chk(1'b0, 1'b0, 1'b0, 0, "R2");
    tick_chk(1'b1, 1'b0, 1'b0, 0, "R2");
    for (int s = 1; s <= 10; s++) tick_chk(1'b0, s == 10, 1'b0, s - 1, "R2 R3");
    for (int i = 10; i <= 160; i++) tick_chk(1'b1, 1'b0, 1'b0, i % 16, "R7");

    // vector table
    for (int v = 0; v < 9; v++) run_vec(VEC[v], v[0]);

    // R8: short frame, high end tick, immediate new edge
    frame_long = 1'b0;
    for (int k = 0; k < 2; k++) tick_chk(1'b1, 1'b0, 1'b0, 0, "R8 idle");
    for (int i = 0; i <= 160; i++)
      tick_chk(i >= 145, (i == 9), 1'b0, i % 16, "R8 short");
    // R8: long frame keeps low samples after 160 inside the frame
    frame_long = 1'b1;
    for (int r = 0; r <= 176; r++)
      tick_chk(1'b0, (r == 9), 1'b0, r % 16, "R8 long");
    // end tick read low: waiting for a high sample
    for (int k = 0; k < 12; k++) tick_chk(1'b0, 1'b0, 1'b0, 0, "R8 rearm");

    // R1: a low level one clock before the tick edge is not seen
    tick_chk(1'b1, 1'b0, 1'b0, 0, "R1 idle");
    @(negedge clk);
    rxd_in = 1'b0;
    @(negedge clk);
    rxd_in = 1'b1;
    tick_16x = 1'b1;
    @(negedge clk);
    tick_16x = 1'b0;
    for (int k = 0; k < 3; k++) tick_chk(1'b1, 1'b0, 1'b0, 0, "R1 late");
    // R1: a one-clock low level two clocks before the tick edge is seen
    @(negedge clk);
    rxd_in = 1'b0;
    @(negedge clk);
    rxd_in = 1'b1;
    @(negedge clk);
    tick_16x = 1'b1;
    @(negedge clk);
    tick_16x = 1'b0;
    chk(phase == 4'd0 && !start_ok && !start_noise, "R1", "edge seen", int'(phase), 0);
    for (int s = 2; s <= 10; s++) tick_chk(1'b1, 1'b0, s == 10, (s == 10) ? 0 : s - 1, "R1 R5");
    for (int k = 0; k < 3; k++) tick_chk(1'b1, 1'b0, 1'b0, 0, "R5 idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule